// File: doc/BRIEF.md
# Real-Time-Clock Register Access Controller

This block is the byte-level back end of a serial-bus real-time-clock target with a 64-byte register space. An external bit-level engine handles bus protocol and device-address matching; it passes this block one-cycle events: a start of a write transfer, a start of a read transfer, a written byte, and a request for the next byte to be read. The block keeps an auto-incrementing register pointer and answers every read from its own stored bytes.

Bytes 0 to 6 of the space are a captured copy of the live time and date, which a separate timekeeping core presents on a flat 56-bit bus. That copy is refreshed on every start of a read and whenever the pointer wraps from the top of the space back to zero. A multi-byte read therefore returns one coherent moment in time even while the clock keeps running. Bytes written to addresses 0 to 6 are not stored. Instead they go out on a time-write port toward the clock core, which sets its counters. Address 7 is a control register with forced-zero bits and a status flag that software can only clear. Addresses 8 to 63 are plain RAM.

A small sequencer follows the transfer phase. Its states are ST_IDLE (after reset), ST_ADDR (the next written byte is a pointer), ST_WRITE (written bytes are data) and ST_READ (after a read start). The transitions are:
- any state goes to ST_ADDR on a write start, or to ST_WRITE if a byte arrives in that same cycle;
- any state goes to ST_READ on a read start;
- ST_ADDR goes to ST_WRITE on a written byte.

Every other condition holds the state.

Top module: `rtcreg_access`

## Requirements
- R1: After reset all 64 bytes read as 0x00, the pointer is 0, rd_data is 0x00, tw_stb is low, and the block is not expecting a pointer byte, so a byte written before any write start is treated as data at address 0.
- R2: The first byte written after start_wr loads the pointer with bits 5:0 of that byte (0x48 selects address 8). A byte that arrives in the same cycle as start_wr is that pointer byte.
- R3: Each later written byte goes to the address in the pointer, and the pointer then advances by one. A byte written to addresses 8 to 63 reads back unchanged.
- R4: A rd_req returns the byte at the pointer on rd_data in the following cycle and advances the pointer by one. rd_data holds its value in every cycle without a read.
- R5: The pointer wraps from 63 to 0 on both reads and writes.
- R6: start_rd copies live_time into addresses 0 to 6, with address i taking live_time[8i+7:8i]. Reads of those addresses return the copy, not later values of live_time, and start_wr does not refresh it.
- R7: A read or write access that wraps the pointer from 63 to 0 also refreshes addresses 0 to 6 from live_time in that same cycle.
- R8: When start_rd and rd_req fall in the same cycle and the pointer is in 0 to 6, the returned byte is the freshly captured live byte.
- R9: A byte written to address 7 is ANDed with 0xB3, so bits 6, 3 and 2 of the control register always read as zero.
- R10: Bit 5 of the control register is the oscillator-stop flag. Writing 0 there clears it, and writing 1 leaves it unchanged. A pulse on osc_fail sets it, and osc_fail wins over a clearing write in the same cycle.
- R11: A data byte written to address 0 to 6 raises tw_stb for exactly one cycle, starting the cycle after the write, with tw_idx equal to the address and tw_data equal to the byte. The stored copy at that address is not changed. tw_stb is low at all other times.
- R12: A rd_req in the same cycle as wr_valid is ignored: the write proceeds, the pointer advances once, and rd_data keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_wr | input | 1 | Pulse: a write transfer has started |
| start_rd | input | 1 | Pulse: a read transfer has started; captures live time |
| wr_valid | input | 1 | Pulse: wr_data holds a received byte |
| wr_data | input | 8 | Received byte (pointer or data) |
| rd_req | input | 1 | Pulse: the engine needs the next read byte |
| rd_data | output | 8 | Read byte, valid the cycle after rd_req |
| live_time | input | 56 | Live time and date from the clock core, byte i at bits 8i+7:8i |
| osc_fail | input | 1 | Pulse from the clock core: the oscillator stopped |
| tw_stb | output | 1 | One-cycle strobe: write a time register in the clock core |
| tw_idx | output | 3 | Time register index for tw_stb |
| tw_data | output | 8 | Time register value for tw_stb |

## Verification
Two functions can land in one cycle: a snapshot of the live time, and a read access at the pointer. This happens in two ways. A read start can coincide with the first byte request, and a read that steps the pointer from 63 to 0 triggers the wrap capture. The bench drives the first case with start_rd and rd_req asserted together at address 0, after changing live_time, and expects the new live byte rather than the old copy. It drives the second case as two reads from address 62 followed by a read at 0, which must show the live value present during the wrapping read. The scoreboard holds the expected bytes, computed from a model that applies the capture before the read in the same cycle.

// File: rtl/rtcr_pkg.sv
package rtcr_pkg;
    localparam int RTCR_AW       = 6;
    localparam int RTCR_DW       = 8;
    localparam int RTCR_TIME_N   = 7;
    localparam int RTCR_CTRL_IDX = 7;
    localparam int RTCR_OSF_BIT  = 5;
    localparam logic [7:0] RTCR_CTRL_KEEP = 8'hB3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WRITE,
        ST_READ
    } seq_state_e;

    // Control byte update: forced-zero bits dropped, status flag may only fall.
    function automatic logic [7:0] ctrl_merge(input logic [7:0] wdat, input logic [7:0] old);
        logic [7:0] res;
        res = wdat & RTCR_CTRL_KEEP;
        res[RTCR_OSF_BIT] = wdat[RTCR_OSF_BIT] & old[RTCR_OSF_BIT];
        return res;
    endfunction
endpackage

// File: rtl/rtcr_seq.sv
module rtcr_seq
    import rtcr_pkg::*;
#(
    parameter int ADDR_W = RTCR_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              start_rd,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr_bits,
    input  logic              rd_req,
    output logic [ADDR_W-1:0] ptr,
    output logic              ptr_load,
    output logic              data_wr_go,
    output logic              rd_go,
    output logic              snap_go
);
    seq_state_e state_q, state_d;
    logic       addr_phase;
    logic       step;
    logic       at_top;

    assign addr_phase = start_wr || (state_q == ST_ADDR);
    assign ptr_load   = wr_valid && addr_phase;
    assign data_wr_go = wr_valid && !addr_phase;
    assign rd_go      = rd_req && !wr_valid;
    assign step       = data_wr_go || rd_go;
    assign at_top     = &ptr;
    assign snap_go    = start_rd || (step && at_top);

    always_comb begin
        state_d = state_q;
        if (start_wr) begin
            state_d = wr_valid ? ST_WRITE : ST_ADDR;
        end else if (start_rd) begin
            state_d = ST_READ;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ADDR:  state_d = wr_valid ? ST_WRITE : ST_ADDR;
                ST_WRITE: state_d = ST_WRITE;
                ST_READ:  state_d = ST_READ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ptr_load) begin
            ptr <= wr_addr_bits;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/rtcr_store.sv
module rtcr_store
    import rtcr_pkg::*;
#(
    parameter int ADDR_W   = RTCR_AW,
    parameter int DATA_W   = RTCR_DW,
    parameter int TIME_N   = RTCR_TIME_N,
    parameter int CTRL_IDX = RTCR_CTRL_IDX
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        ptr,
    input  logic                     data_wr_go,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_go,
    input  logic                     snap_go,
    input  logic [TIME_N*DATA_W-1:0] live_time,
    input  logic                     osc_fail,
    output logic [DATA_W-1:0]        rd_data,
    output logic [DATA_W-1:0]        ctrl_view
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] live_b   [TIME_N];
    logic [DATA_W-1:0] mem_view [DEPTH];
    logic [DATA_W-1:0] rd_sel;

    for (genvar li = 0; li < TIME_N; li++) begin : g_live
        assign live_b[li] = live_time[li*DATA_W +: DATA_W];
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_byte
        logic [DATA_W-1:0] q;
        logic              hit;
        assign hit          = data_wr_go && (ptr == ADDR_W'(gi));
        assign mem_view[gi] = q;

        if (gi < TIME_N) begin : g_time
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (snap_go) begin
                    q <= live_b[gi];
                end
            end
        end else if (gi == CTRL_IDX) begin : g_ctrl
            logic [DATA_W-1:0] nxt;
            always_comb begin
                nxt = q;
                if (hit) begin
                    nxt = ctrl_merge(wr_data, q);
                end
                if (osc_fail) begin
                    nxt[RTCR_OSF_BIT] = 1'b1;
                end
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else begin
                    q <= nxt;
                end
            end
        end else begin : g_ram
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (hit) begin
                    q <= wr_data;
                end
            end
        end
    end

    assign ctrl_view = mem_view[CTRL_IDX];

    // A capture in the read cycle is forwarded so the read sees new data.
    always_comb begin
        rd_sel = mem_view[ptr];
        if (snap_go) begin
            for (int k = 0; k < TIME_N; k++) begin
                if (ptr == ADDR_W'(k)) begin
                    rd_sel = live_b[k];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_go) begin
            rd_data <= rd_sel;
        end
    end
endmodule

// File: rtl/rtcr_timeport.sv
module rtcr_timeport
    import rtcr_pkg::*;
#(
    parameter int ADDR_W = RTCR_AW,
    parameter int DATA_W = RTCR_DW,
    parameter int TIME_N = RTCR_TIME_N,
    localparam int IDX_W = $clog2(TIME_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ptr,
    input  logic              data_wr_go,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tw_stb,
    output logic [IDX_W-1:0]  tw_idx,
    output logic [DATA_W-1:0] tw_data
);
    logic is_time;
    assign is_time = ptr < ADDR_W'(TIME_N);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tw_stb  <= 1'b0;
            tw_idx  <= '0;
            tw_data <= '0;
        end else begin
            tw_stb <= data_wr_go && is_time;
            if (data_wr_go && is_time) begin
                tw_idx  <= ptr[IDX_W-1:0];
                tw_data <= wr_data;
            end
        end
    end
endmodule

// File: rtl/rtcreg_access.sv
module rtcreg_access
    import rtcr_pkg::*;
#(
    parameter int ADDR_W   = RTCR_AW,
    parameter int DATA_W   = RTCR_DW,
    parameter int TIME_N   = RTCR_TIME_N,
    parameter int CTRL_IDX = RTCR_CTRL_IDX,
    localparam int IDX_W   = $clog2(TIME_N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_wr,
    input  logic                     start_rd,
    input  logic                     wr_valid,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_req,
    output logic [DATA_W-1:0]        rd_data,
    input  logic [TIME_N*DATA_W-1:0] live_time,
    input  logic                     osc_fail,
    output logic                     tw_stb,
    output logic [IDX_W-1:0]         tw_idx,
    output logic [DATA_W-1:0]        tw_data
);
    logic [ADDR_W-1:0] cur_ptr;
    logic              ptr_load;
    logic              wr_go;
    logic              rd_go;
    logic              snap_go;
    logic [DATA_W-1:0] ctrl_view;

    rtcr_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_wr     (start_wr),
        .start_rd     (start_rd),
        .wr_valid     (wr_valid),
        .wr_addr_bits (wr_data[ADDR_W-1:0]),
        .rd_req       (rd_req),
        .ptr          (cur_ptr),
        .ptr_load     (ptr_load),
        .data_wr_go   (wr_go),
        .rd_go        (rd_go),
        .snap_go      (snap_go)
    );

    rtcr_store #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .TIME_N   (TIME_N),
        .CTRL_IDX (CTRL_IDX)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr        (cur_ptr),
        .data_wr_go (wr_go),
        .wr_data    (wr_data),
        .rd_go      (rd_go),
        .snap_go    (snap_go),
        .live_time  (live_time),
        .osc_fail   (osc_fail),
        .rd_data    (rd_data),
        .ctrl_view  (ctrl_view)
    );

    rtcr_timeport #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .TIME_N (TIME_N)
    ) u_tport (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr        (cur_ptr),
        .data_wr_go (wr_go),
        .wr_data    (wr_data),
        .tw_stb     (tw_stb),
        .tw_idx     (tw_idx),
        .tw_data    (tw_data)
    );
endmodule

// File: rtl/rtcr_chk.sv
module rtcr_chk
    import rtcr_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_valid,
    input logic [RTCR_DW-1:0]   wr_data,
    input logic                 osc_fail,
    input logic [RTCR_AW-1:0]   cur_ptr,
    input logic                 ptr_load,
    input logic                 wr_go,
    input logic                 rd_go,
    input logic [RTCR_DW-1:0]   ctrl_view,
    input logic [RTCR_DW-1:0]   rd_data,
    input logic                 tw_stb,
    input logic [2:0]           tw_idx
);
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> cur_ptr == $past(wr_data[RTCR_AW-1:0])); // R2

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go || rd_go) |=> cur_ptr == $past(cur_ptr) + 1'b1); // R5

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rd_data)); // R4

    AST_CTRL_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_view & 8'h4C) == 8'h00); // R9

    AST_OSF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_view[RTCR_OSF_BIT] && !osc_fail) |=> !ctrl_view[RTCR_OSF_BIT]); // R10

    AST_TW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tw_stb |-> tw_idx < 3'(RTCR_TIME_N)); // R11

    AST_TW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tw_stb |-> $past(wr_valid)); // R11

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_go && wr_go)); // R12
endmodule

bind rtcreg_access rtcr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .osc_fail  (osc_fail),
    .cur_ptr   (cur_ptr),
    .ptr_load  (ptr_load),
    .wr_go     (wr_go),
    .rd_go     (rd_go),
    .ctrl_view (ctrl_view),
    .rd_data   (rd_data),
    .tw_stb    (tw_stb),
    .tw_idx    (tw_idx)
);

// File: tb/rtcreg_access_bench.sv
`timescale 1ns/1ps
module rtcreg_access_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_wr = 1'b0, start_rd = 1'b0, wr_valid = 1'b0, rd_req = 1'b0, osc_fail = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [55:0] live_time = '0;
    logic [7:0]  rd_data;
    logic        tw_stb;
    logic [2:0]  tw_idx;
    logic [7:0]  tw_data;

    always #2.5 clk = ~clk;

    rtcreg_access u_rtcreg_access (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
        .live_time(live_time), .osc_fail(osc_fail),
        .tw_stb(tw_stb), .tw_idx(tw_idx), .tw_data(tw_data)
    );

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] mdl [64];
    int         m_ptr = 0;
    bit         m_addr = 0;
    bit         rd_seen = 0;

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // Monitor: a read accepted at an edge is compared at the following negedge.
    always @(posedge clk) rd_seen <= rst_n && rd_req && !wr_valid;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) chk("R4 unexpected read", rd_data, 8'hxx);
            else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    function automatic logic [7:0] live_b(input int i);
        return live_time[8*i +: 8];
    endfunction

    task automatic capture();
        for (int i = 0; i < 7; i++) mdl[i] = live_b(i);
    endtask

    task automatic step();
        m_ptr = (m_ptr + 1) % 64;
        if (m_ptr == 0) capture();
    endtask

    function automatic logic [7:0] merge(input logic [7:0] b, input logic [7:0] old);
        return (b & 8'h93) | (b & old & 8'h20);
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic ev_start_wr();
        m_addr = 1; start_wr = 1; tick(); start_wr = 0;
    endtask

    task automatic ev_start_rd();
        capture(); m_addr = 0; start_rd = 1; tick(); start_rd = 0;
    endtask

    task automatic wr_byte(input logic [7:0] b, input bit with_start, input bit with_fail, input string tag);
        bit tw_exp = 0;
        int idx = 0;
        if (with_start) m_addr = 1;
        if (m_addr) begin
            m_ptr = b[5:0]; m_addr = 0;
        end else begin
            if (m_ptr < 7) begin tw_exp = 1; idx = m_ptr; end
            else if (m_ptr == 7) mdl[7] = merge(b, mdl[7]);
            else mdl[m_ptr] = b;
            step();
        end
        if (with_fail) mdl[7][5] = 1'b1;
        start_wr = with_start; osc_fail = with_fail; wr_valid = 1; wr_data = b;
        tick();
        start_wr = 0; osc_fail = 0; wr_valid = 0;
        chk({tag, " R11 strobe"}, {7'd0, tw_stb}, {7'd0, tw_exp});
        if (tw_exp) begin
            chk({tag, " R11 index"}, {5'd0, tw_idx}, 8'(idx));
            chk({tag, " R11 data"}, tw_data, b);
        end
    endtask

    task automatic set_ptr(input logic [7:0] a);
        ev_start_wr(); wr_byte(a, 0, 0, "R2 ptr");
    endtask

    task automatic rd_byte(input bit with_start, input string tag);
        if (with_start) begin capture(); m_addr = 0; end
        exp_q.push_back(mdl[m_ptr]); tag_q.push_back(tag);
        step();
        start_rd = with_start; rd_req = 1; tick(); start_rd = 0; rd_req = 0;
    endtask

    task automatic pulse_fail();
        mdl[7][5] = 1'b1; osc_fail = 1; tick(); osc_fail = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] hold;
        for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        chk("R1 rd_data reset", rd_data, 8'h00);
        chk("R1 tw_stb reset", {7'd0, tw_stb}, 8'h00);
        // R1: no pointer expected after reset, so this byte is data at address 0
        wr_byte(8'h99, 0, 0, "R1 data-not-pointer");
        rd_byte(0, "R1 zero byte at 1");

        // R2 / R3 / R4: RAM writes and reads
        set_ptr(8'h48);
        wr_byte(8'hA1, 0, 0, "R3"); wr_byte(8'hB2, 0, 0, "R3"); wr_byte(8'hC3, 0, 0, "R3");
        set_ptr(8'h08);
        rd_byte(0, "R3 ram 8"); rd_byte(0, "R3 ram 9"); rd_byte(0, "R4 ram 10");
        rd_byte(0, "R1 unwritten ram 11");
        // R2: pointer byte in the same cycle as start_wr
        wr_byte(8'h4A, 1, 0, "R2 same-cycle pointer");
        wr_byte(8'h5C, 0, 0, "R2");
        set_ptr(8'h0A); rd_byte(0, "R2 same-cycle pointer readback");

        // R6: capture on read start, copy stays coherent
        live_time = 56'h24_11_30_05_17_42_59;
        set_ptr(8'h00); ev_start_rd();
        for (int i = 0; i < 8; i++) rd_byte(0, "R6 captured time");
        live_time = 56'h25_12_31_06_23_59_58;
        set_ptr(8'h00); rd_byte(0, "R6 copy not refreshed by start_wr");

        // R11: time write goes to the clock port, not to the copy
        set_ptr(8'h02); wr_byte(8'h45, 0, 0, "R11 time write");
        set_ptr(8'h02); rd_byte(0, "R11 copy unchanged");

        // R9 / R10: control register
        set_ptr(8'h07); wr_byte(8'hFF, 0, 0, "R9");
        set_ptr(8'h07); rd_byte(0, "R9 masked control");
        pulse_fail();
        set_ptr(8'h07); wr_byte(8'hFF, 0, 0, "R10");
        set_ptr(8'h07); rd_byte(0, "R10 flag kept by writing 1");
        set_ptr(8'h07); wr_byte(8'h00, 0, 0, "R10");
        set_ptr(8'h07); rd_byte(0, "R10 flag cleared by writing 0");
        set_ptr(8'h07); wr_byte(8'h00, 0, 1, "R10 clear vs set");
        set_ptr(8'h07); rd_byte(0, "R10 osc_fail wins");

        // R5 / R7: wrap on write and on read
        live_time = 56'h01_02_03_04_05_06_07;
        set_ptr(8'h3E); wr_byte(8'h11, 0, 0, "R5"); wr_byte(8'h22, 0, 0, "R7");
        rd_byte(0, "R7 wrap capture on write");
        live_time = 56'h31_32_33_34_35_36_37;
        set_ptr(8'h3E);
        rd_byte(0, "R5 ram 62"); rd_byte(0, "R5 ram 63");
        live_time = 56'h41_42_43_44_45_46_47;
        rd_byte(0, "R7 wrap capture on read");

        // R8: capture and read in the same cycle
        live_time = 56'h51_52_53_54_55_56_57;
        set_ptr(8'h00);
        rd_byte(1, "R8 same-cycle capture");
        rd_byte(0, "R8 next byte");

        // R12: read request alongside a write is ignored
        tick(); tick();
        hold = rd_data;
        set_ptr(8'h20);
        rd_req = 1;
        wr_byte(8'h77, 0, 0, "R12");
        rd_req = 0;
        tick();
        chk("R12 rd_data unchanged", rd_data, hold);
        set_ptr(8'h20); rd_byte(0, "R12 write took effect");
        set_ptr(8'h21); rd_byte(0, "R12 pointer advanced once");

        tick(); tick();
        chk("R4 all reads returned", 8'(exp_q.size()), 8'h00);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule